// File: doc/BRIEF.md
# Oversampled Asynchronous Receiver with Character Queue

This block turns a single asynchronous serial line into a queue of received characters. It samples the line sixteen times per bit period. Those sample instants come from one of two sources. The first is an internal divider that produces one sample tick every `baud_div + 1` clock cycles. The second is an external clock that runs at sixteen times the bit rate. Its rising edges become sample ticks after synchronisation, and the internal divider is then bypassed. The character format is chosen at run time:

- seven or eight data bits, sent least significant bit first;
- an optional parity bit, either even or odd;
- one or two stop bits.

Each finished character enters a sixteen-entry queue together with three per-character flags: framing error, parity error and break. The head entry is always visible on the read outputs, and a one-cycle `rd_en` pulse removes it. The queue reports a live fill count, a non-empty indication and a full indication. A sticky overrun flag records any character that arrived while the queue was already full; that character is lost.

Top module: `async_rx_fifo`

## Requirements
- R1: A start bit is accepted only when the line is still low at the eighth sample of the bit, counting the sample that saw the falling edge as the first. A shorter low pulse returns the receiver to idle, and nothing is stored.
- R2: With `len7`=0 eight data bits are received; with `len7`=1 seven are received and bit 7 of the stored byte is 0. The first data bit after the start bit lands in bit 0.
- R3: With `par_en`=1 one parity bit follows the data. Parity is computed over the data bits only: `par_odd`=0 expects an even number of ones across data and parity, and `par_odd`=1 expects an odd number. A mismatch sets the stored parity-error flag. With `par_en`=0 no parity bit is expected and the flag is 0.
- R4: The framing-error flag of a character is 1 when its first stop bit samples 0. With `stop2`=1 the second stop bit is not checked, and a start bit that begins during it is received normally.
- R5: The break flag of a character is 1 when its framing-error flag is 1 and every data bit, and the parity bit if one is enabled, sampled 0.
- R6: The queue holds 16 characters in arrival order. The head word appears on `rd_data`, `rd_ferr`, `rd_perr` and `rd_brk`, and an `rd_en` pulse pops it. `fill_count` gives the number stored, `data_ready` is 1 when that number is non-zero, and `fifo_full` is 1 when it equals 16. `rd_en` on an empty queue has no effect.
- R7: A character that completes while 16 entries are stored is discarded and sets `overrun`. This holds even when `rd_en` pops in the same cycle. `overrun` stays 1 until a `clr_ovr` pulse clears it.
- R8: With `ext_sel`=0 sampling follows the internal divider. With `ext_sel`=1 each rising edge of `ext_clk16` gives one sample, and without edges on that input nothing is received.
- R9: After reset `fill_count` is 0, and `data_ready`, `fifo_full` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial receive line, idle high |
| ext_sel | input | 1 | 1 selects the external 16x sample clock, 0 the internal divider |
| ext_clk16 | input | 1 | External clock at 16 times the bit rate |
| baud_div | input | DIV_W | Internal divider: one sample tick every baud_div+1 cycles |
| len7 | input | 1 | 1 selects seven data bits, 0 selects eight |
| par_en | input | 1 | 1 expects a parity bit after the data |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| stop2 | input | 1 | 1 selects two stop bits |
| rd_en | input | 1 | Pop the head character |
| clr_ovr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head character data |
| rd_ferr | output | 1 | Head character framing error |
| rd_perr | output | 1 | Head character parity error |
| rd_brk | output | 1 | Head character break |
| data_ready | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds 16 characters |
| fill_count | output | 5 | Number of stored characters |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The interesting coincidence is a character completing its first stop bit in the same clock cycle in which the reader pops a full queue. Running on the external sample clock makes the completion cycle known in advance. The bench fills the queue with sixteen characters, sends a seventeenth, and raises `rd_en` exactly in the cycle in which the finished character reaches the queue. Afterwards the bench requires three things: `overrun` is set, `fill_count` reads 15, and the remaining entries drain as characters two to sixteen, without the discarded one.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2
   } rxq_state_e;

   // one queue entry: status flags above the received byte
   typedef struct packed {
      logic       brk;
      logic       perr;
      logic       ferr;
      logic [7:0] data;
   } rxq_word_t;

   localparam int unsigned RXQ_WORD_W = $bits(rxq_word_t);

endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("rxq_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= RST_VAL;
         else        chain <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rxq_tick.sv
module rxq_tick #(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_EN      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_sel,
   input  logic             ext_clk,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (DIV_W < 1) begin : g_bad_div
      $error("rxq_tick: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt;
   logic             tick_int;
   logic             tick_ext;

   // free-running divider; ">=" recovers at once if div is lowered
   assign tick_int = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (tick_int) cnt <= '0;
      else               cnt <= cnt + DIV_W'(1);
   end

   if (EXT_EN) begin : g_ext
      logic ext_s;
      logic ext_prev;

      rxq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (ext_clk),
         .q     (ext_s)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ext_prev <= 1'b0;
         else        ext_prev <= ext_s;
      end

      assign tick_ext = ext_s & ~ext_prev;
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ext_clk;
      assign tick_ext   = 1'b0;
   end

   assign tick = ext_sel ? tick_ext : tick_int;

endmodule

// File: rtl/rxq_deser.sv
module rxq_deser
   import rxq_pkg::*;
#(
   parameter int unsigned OVS = 16,
   localparam int unsigned SW = $clog2(OVS)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rx,
   input  logic      len7,
   input  logic      par_en,
   input  logic      par_odd,
   input  logic      stop2,
   output logic      push_v,
   output rxq_word_t push_w
);

   if (OVS < 4 || (1 << SW) != OVS) begin : g_bad_ovs
      $error("rxq_deser: OVS must be a power of two, at least 4");
   end

   localparam logic [SW-1:0] LAST_SMP  = SW'(OVS - 1);
   localparam logic [SW-1:0] START_CHK = SW'(OVS / 2 - 2);

   rxq_state_e  state;
   logic [SW-1:0] scnt;
   logic [2:0]  bidx;
   logic [7:0]  shreg;
   logic        par_bit;
   logic        rx_prev;

   logic        at_end;
   logic        fall;
   logic [2:0]  last_bit;
   logic [7:0]  data_m;
   rxq_word_t   frame_w;

   assign at_end   = (scnt == LAST_SMP);
   assign fall     = ~rx & rx_prev;
   assign last_bit = len7 ? 3'd6 : 3'd7;

   // word assembled at the first stop sample; rx is that stop bit
   always_comb begin
      data_m = shreg;
      if (len7) data_m[7] = 1'b0;
      frame_w.data = data_m;
      frame_w.ferr = ~rx;
      frame_w.perr = par_en & ((^data_m ^ par_bit) != par_odd);
      frame_w.brk  = ~rx & (data_m == 8'h00) & ~(par_en & par_bit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         scnt    <= '0;
         bidx    <= '0;
         shreg   <= '0;
         par_bit <= 1'b0;
         rx_prev <= 1'b1;
         push_v  <= 1'b0;
         push_w  <= '0;
      end else begin
         push_v <= 1'b0;
         if (tick) begin
            rx_prev <= rx;
            unique case (state)
               ST_IDLE: begin
                  if (fall) begin
                     state <= ST_START;
                     scnt  <= '0;
                  end
               end
               ST_START: begin
                  if (scnt == START_CHK) begin
                     if (!rx) begin
                        state <= ST_DATA;
                        scnt  <= '0;
                        bidx  <= '0;
                        shreg <= '0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     scnt <= scnt + SW'(1);
                  end
               end
               ST_DATA: begin
                  if (at_end) begin
                     scnt        <= '0;
                     shreg[bidx] <= rx;
                     if (bidx == last_bit) state <= par_en ? ST_PAR : ST_STOP1;
                     else                  bidx  <= bidx + 3'd1;
                  end else begin
                     scnt <= scnt + SW'(1);
                  end
               end
               ST_PAR: begin
                  if (at_end) begin
                     scnt    <= '0;
                     par_bit <= rx;
                     state   <= ST_STOP1;
                  end else begin
                     scnt <= scnt + SW'(1);
                  end
               end
               ST_STOP1: begin
                  if (at_end) begin
                     scnt   <= '0;
                     push_v <= 1'b1;
                     push_w <= frame_w;
                     state  <= stop2 ? ST_STOP2 : ST_IDLE;
                  end else begin
                     scnt <= scnt + SW'(1);
                  end
               end
               ST_STOP2: begin
                  if (fall) begin
                     state <= ST_START;
                     scnt  <= '0;
                  end else if (at_end) begin
                     state <= ST_IDLE;
                  end else begin
                     scnt <= scnt + SW'(1);
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
   parameter int unsigned WORD_W = 11,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] wdata,
   input  logic              pop,
   output logic [WORD_W-1:0] rdata,
   output logic [CW-1:0]     count,
   output logic              dropped
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("rxq_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr;
   logic [AW-1:0]     rptr;
   logic              is_full;
   logic              is_empty;
   logic              wr;
   logic              rd;

   assign is_full  = (count == CW'(DEPTH));
   assign is_empty = (count == '0);
   // fullness is judged before this cycle's pop: a pop never makes room
   assign wr       = push & ~is_full;
   assign rd       = pop & ~is_empty;
   assign dropped  = push & is_full;
   assign rdata    = mem[rptr];

   always_ff @(posedge clk) begin
      if (wr) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr) wptr <= wptr + AW'(1);
         if (rd) rptr <= rptr + AW'(1);
         unique case ({wr, rd})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
   import rxq_pkg::*;
#(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned FIFO_DEPTH  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OVS         = 16,
   parameter bit          EXT_CLK_EN  = 1'b1,
   localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_in,
   input  logic             ext_sel,
   input  logic             ext_clk16,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             len7,
   input  logic             par_en,
   input  logic             par_odd,
   input  logic             stop2,
   input  logic             rd_en,
   input  logic             clr_ovr,
   output logic [7:0]       rd_data,
   output logic             rd_ferr,
   output logic             rd_perr,
   output logic             rd_brk,
   output logic             data_ready,
   output logic             fifo_full,
   output logic [CNT_W-1:0] fill_count,
   output logic             overrun
);

   logic      tick;
   logic      rx_s;
   logic      push_v;
   rxq_word_t push_w;
   rxq_word_t head_w;
   logic      dropped;

   rxq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_in),
      .q     (rx_s)
   );

   rxq_tick #(
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC_STAGES),
      .EXT_EN      (EXT_CLK_EN)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_sel (ext_sel),
      .ext_clk (ext_clk16),
      .div     (baud_div),
      .tick    (tick)
   );

   rxq_deser #(.OVS(OVS)) u_deser (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .rx      (rx_s),
      .len7    (len7),
      .par_en  (par_en),
      .par_odd (par_odd),
      .stop2   (stop2),
      .push_v  (push_v),
      .push_w  (push_w)
   );

   rxq_fifo #(.WORD_W(RXQ_WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push_v),
      .wdata   (push_w),
      .pop     (rd_en),
      .rdata   (head_w),
      .count   (fill_count),
      .dropped (dropped)
   );

   // a new loss wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       overrun <= 1'b0;
      else if (dropped) overrun <= 1'b1;
      else if (clr_ovr) overrun <= 1'b0;
   end

   assign rd_data    = head_w.data;
   assign rd_ferr    = head_w.ferr;
   assign rd_perr    = head_w.perr;
   assign rd_brk     = head_w.brk;
   assign data_ready = (fill_count != '0);
   assign fifo_full  = (fill_count == CNT_W'(FIFO_DEPTH));

endmodule

// File: rtl/async_rx_fifo_chk.sv
module async_rx_fifo_chk
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          len7,
   input logic          par_en,
   input logic          clr_ovr,
   input logic          data_ready,
   input logic          fifo_full,
   input logic [CW-1:0] fill_count,
   input logic          overrun,
   input logic          push_v,
   input rxq_word_t     push_w
);

   assert_count_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= CW'(DEPTH));

   assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_count == $past(fill_count)) ||
      (fill_count == $past(fill_count) + CW'(1)) ||
      (fill_count + CW'(1) == $past(fill_count)));

   assert_full_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> data_ready);

   assert_ovr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !clr_ovr) |=> overrun);

   assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> ($past(fill_count) == CW'(DEPTH)));

   assert_seven_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_v && $past(len7)) |-> (push_w.data[7] == 1'b0));

   assert_no_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_v && !$past(par_en)) |-> !push_w.perr);

   assert_break_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_v && push_w.brk) |-> push_w.ferr);

endmodule

bind async_rx_fifo async_rx_fifo_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .len7       (len7),
   .par_en     (par_en),
   .clr_ovr    (clr_ovr),
   .data_ready (data_ready),
   .fifo_full  (fifo_full),
   .fill_count (fill_count),
   .overrun    (overrun),
   .push_v     (push_v),
   .push_w     (push_w)
);

// File: tb/sim_async_rx_fifo.sv
module sim_async_rx_fifo;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_in = 1'b1;
   logic        ext_sel = 1'b0;
   logic        ext_clk16 = 1'b0;
   logic [15:0] baud_div = 16'd7;
   logic        len7 = 1'b0;
   logic        par_en = 1'b0;
   logic        par_odd = 1'b0;
   logic        stop2 = 1'b0;
   logic        rd_en = 1'b0;
   logic        clr_ovr = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_ferr;
   logic        rd_perr;
   logic        rd_brk;
   logic        data_ready;
   logic        fifo_full;
   logic [4:0]  fill_count;
   logic        overrun;

   int          total = 0;
   int          fails = 0;
   bit          done = 1'b0;
   bit          exp_ovr = 1'b0;
   logic [10:0] mq[$];
   int unsigned seed_dummy;

   always #2 clk = ~clk;

   async_rx_fifo u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_in      (rx_in),
      .ext_sel    (ext_sel),
      .ext_clk16  (ext_clk16),
      .baud_div   (baud_div),
      .len7       (len7),
      .par_en     (par_en),
      .par_odd    (par_odd),
      .stop2      (stop2),
      .rd_en      (rd_en),
      .clr_ovr    (clr_ovr),
      .rd_data    (rd_data),
      .rd_ferr    (rd_ferr),
      .rd_perr    (rd_perr),
      .rd_brk     (rd_brk),
      .data_ready (data_ready),
      .fifo_full  (fifo_full),
      .fill_count (fill_count),
      .overrun    (overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected entry {brk, perr, ferr, data} from the format rules
   function automatic logic [10:0] exp_word(input logic [7:0] d, input bit flip, input bit stopv);
      logic [7:0] dd;
      logic       pb;
      logic       fe;
      dd = len7 ? {1'b0, d[6:0]} : d;
      pb = (^dd) ^ par_odd ^ flip;
      fe = ~stopv;
      return {fe && (dd == 8'h00) && !(par_en && pb), par_en && flip, fe, dd};
   endfunction

   // one sample period of 8 cycles; ext clock rises at its start
   task automatic one_tick(input bit pulse_ext, input bit pop_mid);
      ext_clk16 = pulse_ext;
      repeat (3) @(negedge clk);
      if (pop_mid) rd_en = 1'b1;
      @(negedge clk);
      rd_en     = 1'b0;
      ext_clk16 = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input bit flip, input bit stopv,
                            input bit short_stop, input bit pop_end, input bit freeze,
                            input int idle_bits);
      logic [10:0] w;
      logic        fr [0:15];
      logic        pb;
      logic [10:0] gone;
      int          nb;
      int          stop_idx;
      w  = exp_word(d, flip, stopv);
      pb = (^w[7:0]) ^ par_odd ^ flip;
      nb = 0;
      fr[nb] = 1'b0; nb++;
      for (int i = 0; i < (len7 ? 7 : 8); i++) begin fr[nb] = w[i]; nb++; end
      if (par_en) begin fr[nb] = pb; nb++; end
      stop_idx = nb;
      fr[nb] = stopv; nb++;
      if (stop2 && !short_stop) begin fr[nb] = 1'b1; nb++; end
      if (!freeze) begin
         if (mq.size() == 16) exp_ovr = 1'b1;
         else                 mq.push_back(w);
      end
      for (int j = 0; j < nb; j++) begin
         rx_in = fr[j];
         for (int t = 0; t < 16; t++)
            one_tick(!freeze && ext_sel, pop_end && (j == stop_idx) && (t == 7));
      end
      if (pop_end && mq.size() > 0) gone = mq.pop_front();
      rx_in = 1'b1;
      for (int k = 0; k < idle_bits * 16; k++) one_tick(!freeze && ext_sel, 1'b0);
   endtask

   task automatic drain(input string tag);
      logic [10:0] e;
      chk({tag, " R6 fill_count"}, fill_count, mq.size());
      chk({tag, " R6 data_ready"}, data_ready, mq.size() != 0);
      chk({tag, " R6 fifo_full"}, fifo_full, mq.size() == 16);
      chk({tag, " R7 overrun"}, overrun, exp_ovr);
      while (mq.size() > 0) begin
         e = mq.pop_front();
         chk({tag, " R6 head word"}, {rd_brk, rd_perr, rd_ferr, rd_data}, e);
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end
      chk({tag, " R6 empty after drain"}, fill_count, 0);
      if (exp_ovr) begin
         clr_ovr = 1'b1;
         @(negedge clk);
         clr_ovr = 1'b0;
         chk({tag, " R7 overrun cleared"}, overrun, 0);
         exp_ovr = 1'b0;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      seed_dummy = $urandom(32'd715);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk("R9 fill_count", fill_count, 0);
      chk("R9 data_ready", data_ready, 0);
      chk("R9 fifo_full", fifo_full, 0);
      chk("R9 overrun", overrun, 0);

      // R8 internal divider, R2 eight bits LSB first
      send_char(8'hA5, 0, 1, 0, 0, 0, 1);
      send_char(8'h3C, 0, 1, 0, 0, 0, 1);
      drain("R8 R2 internal");

      // R1 short low pulse rejected
      rx_in = 1'b0;
      repeat (3) one_tick(1'b0, 1'b0);
      rx_in = 1'b1;
      repeat (40) one_tick(1'b0, 1'b0);
      chk("R1 glitch not stored", fill_count, 0);

      // R2 seven bits with bit 7 forced to 0, R3 odd parity error
      len7 = 1'b1; par_en = 1'b1; par_odd = 1'b1;
      send_char(8'hFF, 0, 1, 0, 0, 0, 1);
      send_char(8'h55, 1, 1, 0, 0, 0, 1);
      drain("R2 R3 seven bit");

      // R5 break vs plain framing error, even parity
      len7 = 1'b0; par_odd = 1'b0;
      send_char(8'h00, 0, 0, 0, 0, 0, 1);
      send_char(8'h00, 0, 1, 0, 0, 0, 1);
      send_char(8'h10, 0, 0, 0, 0, 0, 1);
      send_char(8'h00, 1, 0, 0, 0, 0, 1);
      drain("R5 R4 break");

      // R4 two stop bits, next start inside the second stop bit
      par_en = 1'b0; stop2 = 1'b1;
      send_char(8'h81, 0, 1, 1, 0, 0, 0);
      send_char(8'h7E, 0, 1, 0, 0, 0, 1);
      drain("R4 resync");
      stop2 = 1'b0;

      // R8 external clock: no edges means nothing received
      ext_sel = 1'b1;
      send_char(8'h42, 0, 1, 0, 0, 1, 1);
      chk("R8 no ext edges no data", fill_count, 0);
      send_char(8'h42, 0, 1, 0, 0, 0, 1);
      drain("R8 external");

      // R7 character completes into full queue while reader pops
      for (int n = 0; n < 16; n++) send_char(8'(n * 7 + 1), 0, 1, 0, 0, 0, 0);
      chk("R6 full at sixteen", fifo_full, 1);
      send_char(8'hEE, 0, 1, 0, 1, 0, 1);
      chk("R7 count after pop with drop", fill_count, 15);
      chk("R7 overrun on pop collision", overrun, 1);
      drain("R7 collision");

      // R6 pop on empty has no effect
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R6 pop on empty", fill_count, 0);
      chk("R6 ready on empty", data_ready, 0);

      // constrained random bursts in both clock modes
      for (int b = 0; b < 5; b++) begin
         int len;
         len7    = $urandom % 2;
         par_en  = $urandom % 2;
         par_odd = $urandom % 2;
         stop2   = $urandom % 2;
         ext_sel = $urandom % 2;
         len     = 1 + ($urandom % 12);
         for (int c = 0; c < len; c++) begin
            logic [7:0] d;
            bit         fl;
            bit         sv;
            d  = ($urandom % 6 == 0) ? 8'h00 : 8'($urandom);
            fl = par_en && ($urandom % 4 == 0);
            sv = ($urandom % 5 != 0);
            send_char(d, fl, sv, 0, 0, 0, 1);
         end
         drain("R3 R4 random burst");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule